// File: doc/BRIEF.md
# Dual-Tree Bounding-Volume Traversal Scheduler

This controller walks two binary bounding-volume hierarchies at the same time, depth first, to find every pair of leaf primitives that may touch. It works through one node pair at a time. For an inner pair it streams a fixed number of candidate-axis overlap tests into an external arithmetic pipeline of fixed latency. It keeps its own shift register of tags in step with that pipeline. From the returned per-axis verdicts it either expands the pair into child pairs or drops it. Pairs of two leaves go to an external triangle tester through a request/acknowledge handshake.

Pending pairs are held on a last-in first-out stack, so the search goes deep before it goes wide and the storage stays small. Any triangle hit is flagged at the moment the tester answers. A one-cycle completion pulse marks the end of the query. The `collided` level then tells whether any hit occurred in the run.

Top module: `trav_sched`

## Requirements
- R1: After reset, `busy`, `done`, `axis_valid`, `tri_req`, `hit_valid`, `collided` and `stack_err` are all 0.
- R2: A `start` pulse while idle places the root pair (node 0, node 0) on the stack. Each inner pair then receives axis tests with `axis_id` counting 0, 1, 2 … up to NUM_AXES-1 on consecutive cycles.
- R3: The verdict for a test issued in cycle t is taken from `res_sep` in cycle t+PIPE_LAT, with `res_sep`=1 meaning that axis separates the pair. The pair's last axis is the one with id NUM_AXES-1.
- R4: When the first separating verdict for a pair arrives, no test is issued in that cycle or later for that pair. A pair whose first separating axis is s therefore receives min(NUM_AXES, s+PIPE_LAT) tests. Verdicts still in flight are ignored, and the pair produces no children.
- R5: A pair in which every one of the NUM_AXES verdicts is 0 is expanded into children. Two inner nodes give four pairs. An inner node against a leaf gives two pairs, which descend only the inner side.
- R6: Nodes are numbered as a heap: node i has children 2i+1 and 2i+2. A node of tree A is a leaf when its index is at least 2^DEPTH_A-1, and a node of tree B is a leaf when its index is at least 2^DEPTH_B-1.
- R7: A pair of two leaves receives no axis test. It raises `tri_req` with the two indices on `tri_node_a`/`tri_node_b` and holds them steady until `tri_ack`.
- R8: `hit_valid` is 1 in exactly the cycle where `tri_ack` and `tri_hit` are both 1, with the pair on `hit_node_a`/`hit_node_b`. `collided` goes to 1 from then until the next start.
- R9: `done` pulses for one cycle once the stack is empty and no test is in flight. `busy` is then 0.
- R10: Children are pushed in the order (2a+1,2b+1), (2a+1,2b+2), (2a+2,2b+1), (2a+2,2b+2), or (2a+1,·), (2a+2,·) when only one side descends. The most recently pushed pair is examined next.
- R11: A push onto a full stack is dropped and sets `stack_err`. The flag stays at 1 until the next accepted `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a query (accepted while idle) |
| busy | output | 1 | Query in progress |
| done | output | 1 | One-cycle completion pulse |
| collided | output | 1 | At least one triangle hit in this query |
| stack_err | output | 1 | Sticky stack overflow flag |
| axis_valid | output | 1 | Axis test issued this cycle |
| axis_id | output | AX_W | Candidate axis number |
| axis_node_a | output | IDX_W | Tree A node of the tested pair |
| axis_node_b | output | IDX_W | Tree B node of the tested pair |
| res_sep | input | 1 | Verdict leaving the pipeline: 1 = separated |
| tri_req | output | 1 | Leaf pair waiting for the triangle tester |
| tri_node_a | output | IDX_W | Tree A leaf index |
| tri_node_b | output | IDX_W | Tree B leaf index |
| tri_ack | input | 1 | Triangle tester answers |
| tri_hit | input | 1 | Triangles intersect (valid with tri_ack) |
| hit_valid | output | 1 | Intersecting leaf pair reported |
| hit_node_a | output | IDX_W | Tree A leaf of the hit |
| hit_node_b | output | IDX_W | Tree B leaf of the hit |

## Verification
The bench chases separation at axis 0, at an axis late enough that every test is already issued, and at the final axis. A scheduler that does not cancel would issue all tests after an early verdict. One that ignored late verdicts would expand pairs it should drop. The full visit order is compared with a stack-based software walk that includes the uneven tree depths. This exposes wrong heap arithmetic, wrong child order or a queue used instead of a stack, each of which changes the visit sequence or the hit list. A second copy with a tiny stack must raise and keep its overflow flag, and must clear it again on the next start.

// File: rtl/trav_pkg.sv
// Shared types for the dual-tree traversal scheduler.
// Assumes: node indices use heap numbering, root at index 0.
package trav_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POP,
        ST_ISSUE,
        ST_DRAIN,
        ST_TRI,
        ST_PUSH
    } trav_state_t;

endpackage

// File: rtl/trav_lifo.sv
// Last-in first-out store of node pairs.
// Assumes push and pop are never requested in the same cycle.
// A push while full is dropped and flagged on ovf for that cycle.
module trav_lifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign ovf   = push && full;
    assign dout  = empty ? '0 : mem[AW'(cnt - CW'(1))];

    // Fill count: up on accepted push, down on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push && !full) begin
            cnt <= cnt + CW'(1);
        end else if (pop && !empty) begin
            cnt <= cnt - CW'(1);
        end
    end

    // Entry storage written at the current top.
    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[AW'(cnt)] <= din;
        end
    end

    assert_fill_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    assert_full_push_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (cnt == $past(cnt)));
    assert_no_push_pop_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

endmodule

// File: rtl/trav_tagpipe.sv
// Bookkeeping shift register that runs alongside the axis-test pipeline.
// Assumes the external pipeline has exactly LAT stages and never stalls.
// Each stage carries valid, last-axis flag and the pair's node indices.
module trav_tagpipe #(
    parameter int W   = 8,
    parameter int LAT = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_last,
    input  logic [W-1:0] in_tag,
    output logic         out_valid,
    output logic         out_last,
    output logic [W-1:0] out_tag,
    output logic         busy
);
    logic [LAT-1:0] v_q;
    logic [LAT-1:0] l_q;
    logic [W-1:0]   t_q [LAT];

    // Control bits shift one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            l_q <= '0;
        end else begin
            for (int i = LAT - 1; i > 0; i--) begin
                v_q[i] <= v_q[i-1];
                l_q[i] <= l_q[i-1];
            end
            v_q[0] <= in_valid;
            l_q[0] <= in_last;
        end
    end

    // Node indices shift alongside, no reset needed.
    always_ff @(posedge clk) begin
        for (int i = LAT - 1; i > 0; i--) begin
            t_q[i] <= t_q[i-1];
        end
        t_q[0] <= in_tag;
    end

    assign out_valid = v_q[LAT-1];
    assign out_last  = l_q[LAT-1];
    assign out_tag   = t_q[LAT-1];
    assign busy      = |v_q;

endmodule

// File: rtl/trav_sched.sv
// Dual-tree depth-first traversal scheduler.
// Pops node pairs from a stack. Inner pairs get NUM_AXES axis tests
// through an external pipeline of PIPE_LAT cycles, and the first
// separating verdict cancels the rest. Surviving pairs push their
// children. Leaf pairs go to a triangle tester over a req/ack handshake.
// Assumes DEPTH_A and DEPTH_B are at least 1 and the pipeline never stalls.
module trav_sched #(
    parameter int DEPTH_A     = 3,
    parameter int DEPTH_B     = 2,
    parameter int NUM_AXES    = 24,
    parameter int PIPE_LAT    = 7,
    parameter int STACK_DEPTH = 16,
    localparam int IDX_W = ((DEPTH_A > DEPTH_B) ? DEPTH_A : DEPTH_B) + 1,
    localparam int AX_W  = (NUM_AXES > 1) ? $clog2(NUM_AXES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             collided,
    output logic             stack_err,
    output logic             axis_valid,
    output logic [AX_W-1:0]  axis_id,
    output logic [IDX_W-1:0] axis_node_a,
    output logic [IDX_W-1:0] axis_node_b,
    input  logic             res_sep,
    output logic             tri_req,
    output logic [IDX_W-1:0] tri_node_a,
    output logic [IDX_W-1:0] tri_node_b,
    input  logic             tri_ack,
    input  logic             tri_hit,
    output logic             hit_valid,
    output logic [IDX_W-1:0] hit_node_a,
    output logic [IDX_W-1:0] hit_node_b
);
    import trav_pkg::*;

    localparam int PAIR_W = 2 * IDX_W;
    localparam logic [IDX_W-1:0] LEAF_A = IDX_W'((1 << DEPTH_A) - 1);
    localparam logic [IDX_W-1:0] LEAF_B = IDX_W'((1 << DEPTH_B) - 1);
    localparam logic [AX_W-1:0]  AX_LAST = AX_W'(NUM_AXES - 1);

    trav_state_t       state;
    logic [IDX_W-1:0]  cur_a, cur_b;
    logic [AX_W-1:0]   ax_cnt;
    logic              aborted;
    logic [1:0]        ch_cnt;

    logic              a_leaf, b_leaf;
    logic [IDX_W-1:0]  kid_a, kid_b;
    logic [2:0]        kid_total;
    logic              sep_now;

    logic              stk_push, stk_pop, stk_empty, stk_full, stk_ovf;
    logic [PAIR_W-1:0] stk_din, stk_dout;
    logic              head_valid, head_last, pipe_busy;
    logic [PAIR_W-1:0] head_tag;

    assign a_leaf = (cur_a >= LEAF_A);
    assign b_leaf = (cur_b >= LEAF_B);

    // Child pair selected by ch_cnt; only inner sides descend.
    always_comb begin
        kid_a     = cur_a;
        kid_b     = cur_b;
        kid_total = 3'd2;
        if (!a_leaf && !b_leaf) begin
            kid_total = 3'd4;
            kid_a = (cur_a << 1) + IDX_W'(1) + IDX_W'(ch_cnt[1]);
            kid_b = (cur_b << 1) + IDX_W'(1) + IDX_W'(ch_cnt[0]);
        end else if (!a_leaf) begin
            kid_a = (cur_a << 1) + IDX_W'(1) + IDX_W'(ch_cnt[0]);
        end else begin
            kid_b = (cur_b << 1) + IDX_W'(1) + IDX_W'(ch_cnt[0]);
        end
    end

    // A fresh separating verdict for the pair under test.
    assign sep_now = head_valid && res_sep && !aborted;

    assign axis_valid  = (state == ST_ISSUE) && !sep_now;
    assign axis_id     = ax_cnt;
    assign axis_node_a = cur_a;
    assign axis_node_b = cur_b;

    assign tri_req    = (state == ST_TRI);
    assign tri_node_a = cur_a;
    assign tri_node_b = cur_b;
    assign hit_valid  = tri_req && tri_ack && tri_hit;
    assign hit_node_a = cur_a;
    assign hit_node_b = cur_b;
    assign busy       = (state != ST_IDLE);

    assign stk_push = ((state == ST_IDLE) && start) || (state == ST_PUSH);
    assign stk_pop  = (state == ST_POP) && !stk_empty;
    assign stk_din  = (state == ST_IDLE) ? '0 : {kid_a, kid_b};

    trav_lifo #(.W(PAIR_W), .DEPTH(STACK_DEPTH)) i_lifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stk_push),
        .pop   (stk_pop),
        .din   (stk_din),
        .dout  (stk_dout),
        .empty (stk_empty),
        .full  (stk_full),
        .ovf   (stk_ovf)
    );

    trav_tagpipe #(.W(PAIR_W), .LAT(PIPE_LAT)) i_tagpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (axis_valid),
        .in_last   (ax_cnt == AX_LAST),
        .in_tag    ({cur_a, cur_b}),
        .out_valid (head_valid),
        .out_last  (head_last),
        .out_tag   (head_tag),
        .busy      (pipe_busy)
    );

    // Traversal sequencing: pop, test, drain, expand or hand off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_a     <= '0;
            cur_b     <= '0;
            ax_cnt    <= '0;
            aborted   <= 1'b0;
            ch_cnt    <= '0;
            collided  <= 1'b0;
            stack_err <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        collided  <= 1'b0;
                        stack_err <= 1'b0;
                        state     <= ST_POP;
                    end
                end
                ST_POP: begin
                    if (stk_empty) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        cur_a   <= stk_dout[PAIR_W-1:IDX_W];
                        cur_b   <= stk_dout[IDX_W-1:0];
                        ax_cnt  <= '0;
                        aborted <= 1'b0;
                        if ((stk_dout[PAIR_W-1:IDX_W] >= LEAF_A) &&
                            (stk_dout[IDX_W-1:0] >= LEAF_B)) begin
                            state <= ST_TRI;
                        end else begin
                            state <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (sep_now) begin
                        aborted <= 1'b1;
                        state   <= ST_DRAIN;
                    end else begin
                        ax_cnt <= ax_cnt + AX_W'(1);
                        if (ax_cnt == AX_LAST) begin
                            state <= ST_DRAIN;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (aborted) begin
                        if (!pipe_busy) begin
                            state <= ST_POP;
                        end
                    end else if (head_valid) begin
                        if (res_sep) begin
                            aborted <= 1'b1;
                        end else if (head_last) begin
                            ch_cnt <= '0;
                            state  <= ST_PUSH;
                        end
                    end
                end
                ST_TRI: begin
                    if (tri_ack) begin
                        if (tri_hit) begin
                            collided <= 1'b1;
                        end
                        state <= ST_POP;
                    end
                end
                ST_PUSH: begin
                    ch_cnt <= ch_cnt + 2'd1;
                    if ({1'b0, ch_cnt} == kid_total - 3'd1) begin
                        state <= ST_POP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (stk_ovf) begin
                stack_err <= 1'b1;
            end
        end
    end

    assert_cancel_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        aborted |-> !axis_valid);
    assert_head_matches_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid |-> (head_tag == {cur_a, cur_b}));
    assert_leaf_pair_no_axis_R7: assert property (@(posedge clk) disable iff (!rst_n)
        axis_valid |-> !(a_leaf && b_leaf));
    assert_tri_request_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tri_req && !tri_ack) |=> (tri_req && $stable(tri_node_a) && $stable(tri_node_b)));
    assert_done_when_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (stk_empty && !pipe_busy && !busy));
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_err && !start) |=> stack_err);
    assert_axis_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        axis_valid |-> (axis_id <= AX_LAST));

endmodule

// File: tb/test_trav_sched.sv
module test_trav_sched;
    localparam int CLK_PERIOD = 10;
    localparam int DA   = 3;
    localparam int DB   = 2;
    localparam int NAX  = 24;
    localparam int LAT  = 7;
    localparam int SDEP = 16;
    localparam int IW   = 4;
    localparam int AXW  = 5;
    localparam int NA   = (1 << (DA + 1)) - 1;
    localparam int NB   = (1 << (DB + 1)) - 1;
    localparam int LOGN = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, collided, stack_err;
    logic axis_valid;
    logic [AXW-1:0] axis_id;
    logic [IW-1:0] axis_node_a, axis_node_b;
    logic res_sep;
    logic tri_req, tri_ack, tri_hit;
    logic [IW-1:0] tri_node_a, tri_node_b;
    logic hit_valid;
    logic [IW-1:0] hit_node_a, hit_node_b;

    logic s_busy, s_done, s_coll, s_err, s_axv, s_treq, s_hitv;
    logic [AXW-1:0] s_axid;
    logic [IW-1:0] s_axa, s_axb, s_ta, s_tb, s_ha, s_hb;

    int  sepax [NA][NB];
    bit  trih  [NA][NB];
    logic [LAT-1:0] pv, ps;

    int n_cmp = 0;
    int n_bad = 0;

    int mon_va [LOGN];
    int mon_vb [LOGN];
    int mon_nv, mon_issues, mon_order_err, mon_nh;
    int mon_ha [LOGN];
    int mon_hb [LOGN];
    bit prev_v, prev_tri;
    int prev_id;

    int ref_va [LOGN];
    int ref_vb [LOGN];
    int ref_nv, ref_issues, ref_nh;
    int ref_ha [LOGN];
    int ref_hb [LOGN];

    always #(CLK_PERIOD / 2) clk = ~clk;

    trav_sched #(.DEPTH_A(DA), .DEPTH_B(DB), .NUM_AXES(NAX), .PIPE_LAT(LAT),
                 .STACK_DEPTH(SDEP)) i_trav_sched (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .collided(collided), .stack_err(stack_err), .axis_valid(axis_valid),
        .axis_id(axis_id), .axis_node_a(axis_node_a), .axis_node_b(axis_node_b),
        .res_sep(res_sep), .tri_req(tri_req), .tri_node_a(tri_node_a),
        .tri_node_b(tri_node_b), .tri_ack(tri_ack), .tri_hit(tri_hit),
        .hit_valid(hit_valid), .hit_node_a(hit_node_a), .hit_node_b(hit_node_b)
    );

    // Tiny-stack copy: never separates, never hits, so it must overflow.
    trav_sched #(.DEPTH_A(DA), .DEPTH_B(DB), .NUM_AXES(NAX), .PIPE_LAT(LAT),
                 .STACK_DEPTH(4)) i_trav_sched_small (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(s_busy), .done(s_done),
        .collided(s_coll), .stack_err(s_err), .axis_valid(s_axv),
        .axis_id(s_axid), .axis_node_a(s_axa), .axis_node_b(s_axb),
        .res_sep(1'b0), .tri_req(s_treq), .tri_node_a(s_ta),
        .tri_node_b(s_tb), .tri_ack(s_treq), .tri_hit(1'b0),
        .hit_valid(s_hitv), .hit_node_a(s_ha), .hit_node_b(s_hb)
    );

    // Behavioural axis pipeline: verdict = axis id at or past the table entry.
    always @(posedge clk) begin
        if (!rst_n) begin
            pv <= '0;
            ps <= '0;
        end else begin
            pv <= {pv[LAT-2:0], axis_valid};
            ps <= {ps[LAT-2:0], axis_valid && (int'(axis_node_a) < NA) &&
                   (int'(axis_node_b) < NB) &&
                   (int'(axis_id) >= sepax[int'(axis_node_a) % NA][int'(axis_node_b) % NB])};
        end
    end
    assign res_sep = ps[LAT-1];

    // Behavioural triangle tester: answers one cycle after the request.
    always @(posedge clk) begin
        if (!rst_n) begin
            tri_ack <= 1'b0;
            tri_hit <= 1'b0;
        end else begin
            tri_ack <= tri_req && !tri_ack;
            tri_hit <= trih[int'(tri_node_a) % NA][int'(tri_node_b) % NB];
        end
    end

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (axis_valid) begin
            mon_issues++;
            if (axis_id == '0) begin
                if (mon_nv < LOGN) begin
                    mon_va[mon_nv] = int'(axis_node_a);
                    mon_vb[mon_nv] = int'(axis_node_b);
                end
                mon_nv++;
            end else if (!(prev_v && int'(axis_id) == prev_id + 1)) begin
                mon_order_err++;
            end
        end
        if (tri_req && !prev_tri) begin
            if (mon_nv < LOGN) begin
                mon_va[mon_nv] = int'(tri_node_a);
                mon_vb[mon_nv] = int'(tri_node_b);
            end
            mon_nv++;
        end
        if (hit_valid) begin
            if (mon_nh < LOGN) begin
                mon_ha[mon_nh] = int'(hit_node_a);
                mon_hb[mon_nh] = int'(hit_node_b);
            end
            mon_nh++;
        end
        prev_v   = axis_valid;
        prev_id  = int'(axis_id);
        prev_tri = tri_req;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference walk: explicit stack, children pushed in R10 order.
    task automatic ref_walk();
        int sa [64];
        int sb [64];
        int sp = 1;
        sa[0] = 0;
        sb[0] = 0;
        ref_nv = 0;
        ref_issues = 0;
        ref_nh = 0;
        while (sp > 0) begin
            int a, b;
            bit la, lb;
            sp--;
            a = sa[sp];
            b = sb[sp];
            if (ref_nv < LOGN) begin
                ref_va[ref_nv] = a;
                ref_vb[ref_nv] = b;
            end
            ref_nv++;
            la = (a >= (1 << DA) - 1);
            lb = (b >= (1 << DB) - 1);
            if (la && lb) begin
                if (trih[a][b]) begin
                    if (ref_nh < LOGN) begin
                        ref_ha[ref_nh] = a;
                        ref_hb[ref_nh] = b;
                    end
                    ref_nh++;
                end
            end else if (sepax[a][b] < NAX) begin
                ref_issues += (sepax[a][b] + LAT < NAX) ? sepax[a][b] + LAT : NAX;
            end else begin
                ref_issues += NAX;
                if (!la && !lb) begin
                    for (int k = 0; k < 4; k++) begin
                        sa[sp] = 2 * a + 1 + k / 2;
                        sb[sp] = 2 * b + 1 + k % 2;
                        sp++;
                    end
                end else if (!la) begin
                    for (int k = 0; k < 2; k++) begin
                        sa[sp] = 2 * a + 1 + k;
                        sb[sp] = b;
                        sp++;
                    end
                end else begin
                    for (int k = 0; k < 2; k++) begin
                        sa[sp] = a;
                        sb[sp] = 2 * b + 1 + k;
                        sp++;
                    end
                end
            end
        end
    endtask

    task automatic fill_tables(input int sep_pct, input int hit_pct);
        for (int a = 0; a < NA; a++) begin
            for (int b = 0; b < NB; b++) begin
                sepax[a][b] = (($urandom % 100) < sep_pct) ? int'($urandom % NAX) : NAX;
                trih[a][b]  = (($urandom % 100) < hit_pct);
            end
        end
    endtask

    task automatic run_case(input string name);
        int cyc;
        int mis;
        bit got_done;
        ref_walk();
        @(negedge clk);
        mon_nv = 0;
        mon_issues = 0;
        mon_order_err = 0;
        mon_nh = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(stack_err == 1'b0 && s_err == 1'b0, "R11", {name, " flags cleared by start"},
              int'(s_err), 0);
        check(busy == 1'b1, "R2", {name, " busy after start"}, int'(busy), 1);
        got_done = 1'b0;
        cyc = 0;
        while (!got_done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (done) begin
                got_done = 1'b1;
                check(busy == 1'b0, "R9", {name, " idle with done"}, int'(busy), 0);
                check(collided == (ref_nh > 0), "R8", {name, " collided level"},
                      int'(collided), int'(ref_nh > 0));
            end
        end
        check(got_done, "R9", {name, " done pulse seen"}, int'(got_done), 1);
        cyc = 0;
        while (s_busy && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        check(mon_nv == ref_nv, "R10", {name, " pairs visited"}, mon_nv, ref_nv);
        mis = -1;
        for (int i = 0; i < ref_nv && i < mon_nv && i < LOGN; i++) begin
            if (mis < 0 && (mon_va[i] != ref_va[i] || mon_vb[i] != ref_vb[i])) mis = i;
        end
        check(mis < 0, "R5 R6 R10", {name, " visit order first mismatch index"}, mis, -1);
        check(mon_issues == ref_issues, "R4", {name, " axis tests issued"},
              mon_issues, ref_issues);
        check(mon_order_err == 0, "R2 R3", {name, " axis id sequence breaks"},
              mon_order_err, 0);
        check(mon_nh == ref_nh, "R7 R8", {name, " hit count"}, mon_nh, ref_nh);
        mis = -1;
        for (int i = 0; i < ref_nh && i < mon_nh && i < LOGN; i++) begin
            if (mis < 0 && (mon_ha[i] != ref_ha[i] || mon_hb[i] != ref_hb[i])) mis = i;
        end
        check(mis < 0, "R8", {name, " hit list first mismatch index"}, mis, -1);
        check(stack_err == 1'b0, "R11", {name, " no overflow with ample stack"},
              int'(stack_err), 0);
        check(s_err == 1'b1 && !s_busy, "R11", {name, " tiny stack overflow sticky"},
              int'(s_err), 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < NA; a++) begin
            for (int b = 0; b < NB; b++) begin
                sepax[a][b] = NAX;
                trih[a][b] = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        check(done == 1'b0, "R1", "done after reset", int'(done), 0);
        check(axis_valid == 1'b0 && tri_req == 1'b0, "R1", "no request after reset",
              int'(axis_valid), 0);
        check(collided == 1'b0 && hit_valid == 1'b0, "R1", "no hit after reset",
              int'(collided), 0);
        check(stack_err == 1'b0, "R1", "stack_err after reset", int'(stack_err), 0);

        // Nothing separates, no triangle hits: full walk, disjoint result.
        run_case("all-overlap-nohit");
        // Root separated on axis 0: cancel after PIPE_LAT issues (R4).
        sepax[0][0] = 0;
        run_case("root-sep-axis0");
        // Root separated late: all tests already issued, no children.
        sepax[0][0] = 20;
        run_case("root-sep-axis20");
        // Separation only on the final axis.
        sepax[0][0] = NAX - 1;
        run_case("root-sep-lastaxis");
        // Everything overlaps and every leaf pair hits.
        sepax[0][0] = NAX;
        for (int a = 0; a < NA; a++) begin
            for (int b = 0; b < NB; b++) trih[a][b] = 1'b1;
        end
        run_case("all-hit");
        // Random tables.
        for (int r = 0; r < 4; r++) begin
            fill_tables(35, 30);
            sepax[0][0] = NAX;
            run_case($sformatf("random-%0d", r));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Global watchdog: counts as a failed check and still summarises.
    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule